// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Replacement

This block sits between a bank of timer channels and the interrupt fabric. Each channel raises a one-cycle fire strobe when its comparator matches; the router turns that strobe into activity on one of a vector of interrupt lines. The choice depends on the channel's configuration and on two global controls. A channel in level mode latches a status bit and holds its line until software clears the status. A channel in edge mode emits a single-cycle pulse. A channel in message mode raises a 32-bit write request instead of touching any line.

A global legacy-replacement control takes over two fixed lines. Channel 0 is steered to line 0 and channel 1 to line 8, and the external interval-timer and real-time-clock inputs are no longer forwarded to those lines. Outside legacy mode those two inputs pass through to lines 0 and 8. The real-time-clock level is latched at all times, so line 8 comes back with the current level when legacy mode ends. An interval-timer enable output tells the external interval timer whether it still owns line 0. Lines numbered 16 and above use active-low signalling. Every output is registered and follows its cause by one clock.

Top module: `irq_router`

## Requirements
- R1: After reset every line is deasserted (lines 0 to 15 read 0, lines 16 to 23 read 1), all status bits are 0, the interval-timer enable output is 1 and no message request is raised.
- R2: A line numbered 16 or above is asserted by driving it to 0; lines below 16 are asserted by driving 1.
- R3: A fire on an enabled level-mode channel (channel enable and global enable both 1) sets that channel's status bit and asserts its line from the next cycle on, and both stay set for as long as no clear, fire or message-enable rise arrives.
- R4: A clear request for a channel drops its status bit and its level line on the next cycle; when a fire and a clear arrive in the same cycle, the fire decides the result.
- R5: A fire on an enabled edge-mode channel asserts its line for exactly one cycle and leaves its status bit at 0.
- R6: A fire on a channel whose channel enable or the global enable is 0 clears its status bit and asserts no line.
- R7: A channel drives the line whose number equals its 5-bit route field, except that in legacy mode channel 0 drives line 0 and channel 1 drives line 8; other channels keep their route field in legacy mode.
- R8: A fire on an enabled channel with message mode on drives no line, leaves its status unchanged, and raises the message request for one cycle. The message data carries bits 31:0 of the channel's 64-bit message word and the address carries bits 63:32. Address and data then hold until the acknowledge input is seen. While a message waits for its acknowledge, further message fires are dropped. Among channels that fire in the same cycle, the lowest-numbered one wins.
- R9: A rise of a channel's message-mode bit clears its status bit on the next cycle.
- R10: Outside legacy mode, the interval-timer input appears on line 0 and the real-time-clock input on line 8 one cycle later.
- R11: Entering legacy mode drives the interval-timer enable output to 0 on the next cycle, and the two external inputs no longer reach lines 0 and 8.
- R12: Leaving legacy mode raises the interval-timer enable output on the next cycle and holds line 0 deasserted for that one cycle. In that same cycle line 8 takes the latched real-time-clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fire_i | input | NUM_CH | One-cycle fire strobe per channel |
| ch_en_i | input | NUM_CH | Per-channel interrupt enable |
| ch_level_i | input | NUM_CH | Per-channel mode: 1 level, 0 edge |
| ch_msg_i | input | NUM_CH | Per-channel message-mode enable |
| ch_route_i | input | NUM_CH*ROUTE_W | Route field per channel, channel c in bits c*ROUTE_W upward |
| ch_msg_route_i | input | NUM_CH*64 | Message word per channel: address high half, data low half |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy-replacement mode |
| clr_i | input | NUM_CH | Status clear request per channel |
| pit_i | input | 1 | External interval-timer interrupt input |
| rtc_i | input | 1 | External real-time-clock interrupt input |
| msg_ack_i | input | 1 | Acknowledge of the pending message write |
| irq_o | output | NUM_LINES | Interrupt lines, 16 and above active-low |
| status_o | output | NUM_CH | Per-channel status bits |
| pit_en_o | output | 1 | Interval-timer enable, low in legacy mode |
| msg_req_o | output | 1 | One-cycle message write request |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
A table of single fires on one channel sweeps route numbers across both polarity halves and crosses level against edge mode with each enable off in turn. Comparing the whole line vector shows a wrong line, a wrong polarity and a stray second line apart, and the follow-up clear shows a held level from a single pulse. Directed sequences then fire channels 0, 1 and 2 with the same route under legacy mode, which separates the override from plain routing. The legacy control is toggled while both external inputs are high, so the pass-through, the one-cycle drop of line 0 and the restored clock level can each be seen. Message fires are issued single, while busy, after an acknowledge and from two channels at once, which tests the hold, the drop and the priority.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;

    localparam int MSG_HALF_W = 32;
    localparam int MSG_WORD_W = 2 * MSG_HALF_W;

    typedef struct packed {
        logic [MSG_HALF_W-1:0] addr;
        logic [MSG_HALF_W-1:0] data;
    } msg_word_t;

endpackage

// File: rtl/irq_rt_route_map.sv
module irq_rt_route_map #(
    parameter int NUM_CH     = 4,
    parameter int ROUTE_W    = 5,
    parameter int LEG_LINE_A = 0,
    parameter int LEG_LINE_B = 8
) (
    input  logic [NUM_CH*ROUTE_W-1:0] route_i,
    input  logic                      legacy_i,
    output logic [ROUTE_W-1:0]        eff_o [NUM_CH]
);

    localparam logic [ROUTE_W-1:0] LINE_A = ROUTE_W'(LEG_LINE_A);
    localparam logic [ROUTE_W-1:0] LINE_B = ROUTE_W'(LEG_LINE_B);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c == 0) begin : g_first
            assign eff_o[c] = legacy_i ? LINE_A : route_i[c*ROUTE_W +: ROUTE_W];
        end else if (c == 1) begin : g_second
            assign eff_o[c] = legacy_i ? LINE_B : route_i[c*ROUTE_W +: ROUTE_W];
        end else begin : g_plain
            assign eff_o[c] = route_i[c*ROUTE_W +: ROUTE_W];
        end
    end

endmodule

// File: rtl/irq_rt_msg.sv
module irq_rt_msg
    import irq_rt_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            send_i,
    input  logic [NUM_CH*MSG_WORD_W-1:0] word_i,
    input  logic                         ack_i,
    output logic                         req_o,
    output logic [MSG_HALF_W-1:0]        addr_o,
    output logic [MSG_HALF_W-1:0]        data_o
);

    typedef struct packed {
        logic      busy;
        logic      req;
        msg_word_t word;
    } mst_t;

    mst_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.req = 1'b0;
        if (m_q.busy && ack_i) begin
            m_d.busy = 1'b0;
        end
        if (!m_q.busy) begin
            // scan downward so the lowest firing channel is the last written
            for (int c = NUM_CH - 1; c >= 0; c--) begin
                if (send_i[c]) begin
                    m_d.word = msg_word_t'(word_i[c*MSG_WORD_W +: MSG_WORD_W]);
                    m_d.req  = 1'b1;
                    m_d.busy = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign req_o  = m_q.req;
    assign addr_o = m_q.word.addr;
    assign data_o = m_q.word.data;

    // R8: the request strobe lasts a single cycle
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_q.req |=> !m_q.req);

    // R8: address and data stay put while waiting for the acknowledge
    p_word_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_q.busy && !m_q.req) |-> $stable(m_q.word));

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_rt_pkg::*;
#(
    parameter  int NUM_CH     = 4,
    parameter  int NUM_LINES  = 24,
    parameter  int INV_BASE   = 16,
    parameter  int LEG_LINE_A = 0,
    parameter  int LEG_LINE_B = 8,
    localparam int ROUTE_W    = $clog2(NUM_LINES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            fire_i,
    input  logic [NUM_CH-1:0]            ch_en_i,
    input  logic [NUM_CH-1:0]            ch_level_i,
    input  logic [NUM_CH-1:0]            ch_msg_i,
    input  logic [NUM_CH*ROUTE_W-1:0]    ch_route_i,
    input  logic [NUM_CH*MSG_WORD_W-1:0] ch_msg_route_i,
    input  logic                         glb_en_i,
    input  logic                         legacy_i,
    input  logic [NUM_CH-1:0]            clr_i,
    input  logic                         pit_i,
    input  logic                         rtc_i,
    input  logic                         msg_ack_i,
    output logic [NUM_LINES-1:0]         irq_o,
    output logic [NUM_CH-1:0]            status_o,
    output logic                         pit_en_o,
    output logic                         msg_req_o,
    output logic [MSG_HALF_W-1:0]        msg_addr_o,
    output logic [MSG_HALF_W-1:0]        msg_data_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0] line;    // logical assertion, before polarity
        logic [NUM_CH-1:0]    stat;
        logic [NUM_CH-1:0]    msg_en;
        logic                 legacy;
        logic                 rtc_lat;
    } st_t;

    st_t st_d, st_q;

    logic [ROUTE_W-1:0] eff_route [NUM_CH];
    logic [NUM_CH-1:0]  go;
    logic [NUM_CH-1:0]  send;
    logic               leaving;

    irq_rt_route_map #(
        .NUM_CH     (NUM_CH),
        .ROUTE_W    (ROUTE_W),
        .LEG_LINE_A (LEG_LINE_A),
        .LEG_LINE_B (LEG_LINE_B)
    ) u_map (
        .route_i  (ch_route_i),
        .legacy_i (legacy_i),
        .eff_o    (eff_route)
    );

    assign go      = ch_en_i & {NUM_CH{glb_en_i}};
    assign send    = fire_i & go & ch_msg_i;
    assign leaving = st_q.legacy & ~legacy_i;

    always_comb begin
        st_d         = st_q;
        st_d.legacy  = legacy_i;
        st_d.rtc_lat = rtc_i;
        st_d.msg_en  = ch_msg_i;

        for (int c = 0; c < NUM_CH; c++) begin
            if (clr_i[c]) begin
                st_d.stat[c] = 1'b0;
            end
            if (fire_i[c]) begin
                if (!go[c]) begin
                    st_d.stat[c] = 1'b0;
                end else if (!ch_msg_i[c]) begin
                    st_d.stat[c] = ch_level_i[c];
                end
            end
            if (ch_msg_i[c] && !st_q.msg_en[c]) begin
                st_d.stat[c] = 1'b0;
            end
        end

        st_d.line = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (!ch_msg_i[c] && int'(eff_route[c]) < NUM_LINES) begin
                if (st_d.stat[c] && ch_level_i[c]) begin
                    st_d.line[eff_route[c]] = 1'b1;
                end
                if (fire_i[c] && go[c] && !ch_level_i[c]) begin
                    st_d.line[eff_route[c]] = 1'b1;
                end
            end
        end

        if (!legacy_i) begin
            st_d.line[LEG_LINE_A] = st_d.line[LEG_LINE_A] | (pit_i & ~leaving);
            st_d.line[LEG_LINE_B] = st_d.line[LEG_LINE_B] | st_d.rtc_lat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_pol
        if (l >= INV_BASE) begin : g_low
            assign irq_o[l] = ~st_q.line[l];
        end else begin : g_high
            assign irq_o[l] = st_q.line[l];
        end
    end

    assign status_o = st_q.stat;
    assign pit_en_o = ~st_q.legacy;

    irq_rt_msg #(
        .NUM_CH (NUM_CH)
    ) u_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .send_i (send),
        .word_i (ch_msg_route_i),
        .ack_i  (msg_ack_i),
        .req_o  (msg_req_o),
        .addr_o (msg_addr_o),
        .data_o (msg_data_o)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R4: a lone clear empties the status bit
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[c] && !fire_i[c]) |=> !status_o[c]);

        // R3: a set status bit holds when nothing acts on it
        p_level_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (status_o[c] && !clr_i[c] && !fire_i[c] && !(ch_msg_i[c] && !st_q.msg_en[c]))
            |=> status_o[c]);
    end

    // R11: legacy mode takes the enable output low
    p_pit_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> !pit_en_o);

    // R10: clock input reaches its line outside legacy mode
    p_rtc_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_i && rtc_i) |=> st_q.line[LEG_LINE_B]);

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

    localparam int NCH = 4;
    localparam int NL  = 24;
    localparam int RW  = 5;
    localparam logic [NL-1:0] IDLE = {8'hFF, 16'h0000};

    typedef struct packed {
        logic [RW-1:0] route;
        logic          level;
        logic          chen;
        logic          glben;
        logic          exp_stat;
        logic          exp_act;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VEC [NVEC] = '{
        '{5'd3,  1'b1, 1'b1, 1'b1, 1'b1, 1'b1},   // R3 level, low line
        '{5'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},   // R5 edge
        '{5'd17, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},   // R2 level, active-low line
        '{5'd23, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},   // R2 edge, top line
        '{5'd5,  1'b1, 1'b0, 1'b1, 1'b0, 1'b0},   // R6 channel off
        '{5'd5,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0},   // R6 global off
        '{5'd20, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},   // R6 edge, global off
        '{5'd12, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}    // R7 plain route
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] fire = '0, ch_en = '0, ch_level = '0, ch_msg = '0, clr = '0;
    logic [NCH*RW-1:0] route = '0;
    logic [NCH*64-1:0] mroute = '0;
    logic glb_en = 1'b0, legacy = 1'b0, pit = 1'b0, rtc = 1'b0, ack = 1'b0;

    logic [NL-1:0]  irq;
    logic [NCH-1:0] status;
    logic           pit_en, msg_req;
    logic [31:0]    msg_addr, msg_data;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_router dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fire_i         (fire),
        .ch_en_i        (ch_en),
        .ch_level_i     (ch_level),
        .ch_msg_i       (ch_msg),
        .ch_route_i     (route),
        .ch_msg_route_i (mroute),
        .glb_en_i       (glb_en),
        .legacy_i       (legacy),
        .clr_i          (clr),
        .pit_i          (pit),
        .rtc_i          (rtc),
        .msg_ack_i      (msg_ack_i_w),
        .irq_o          (irq),
        .status_o       (status),
        .pit_en_o       (pit_en),
        .msg_req_o      (msg_req),
        .msg_addr_o     (msg_addr),
        .msg_data_o     (msg_data)
    );

    logic msg_ack_i_w;
    assign msg_ack_i_w = ack;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [NL-1:0] on(input int l);
        return IDLE ^ (NL'(1) << l);
    endfunction

    task automatic set_route(input int c, input logic [RW-1:0] r);
        route[c*RW +: RW] = r;
    endtask

    task automatic pulse_fire(input logic [NCH-1:0] m);
        fire = m;
        tick();
        fire = '0;
    endtask

    task automatic pulse_clr(input logic [NCH-1:0] m);
        clr = m;
        tick();
        clr = '0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 lines", 64'(irq), 64'(IDLE));
        chk("R1 status", 64'(status), 64'h0);
        chk("R1 pit_en", 64'(pit_en), 64'h1);
        chk("R1 msg_req", 64'(msg_req), 64'h0);

        // table walk on channel 2
        for (int i = 0; i < NVEC; i++) begin
            ch_en[2]    = VEC[i].chen;
            glb_en      = VEC[i].glben;
            ch_level[2] = VEC[i].level;
            set_route(2, VEC[i].route);
            pulse_fire(4'b0100);
            chk($sformatf("R3/R5/R6 vec%0d status", i), 64'(status[2]), 64'(VEC[i].exp_stat));
            chk($sformatf("R2/R7 vec%0d lines", i), 64'(irq),
                64'(VEC[i].exp_act ? on(int'(VEC[i].route)) : IDLE));
            pulse_clr(4'b0100);
            chk($sformatf("R4/R5 vec%0d after", i), 64'(irq), 64'(IDLE));
        end

        // R3 level holds across idle cycles
        ch_en = '1; glb_en = 1'b1; ch_level[2] = 1'b1; set_route(2, 5'd5);
        pulse_fire(4'b0100);
        tick(); tick();
        chk("R3 held", 64'(irq), 64'(on(5)));
        // R4 fire beats clear in the same cycle
        fire = 4'b0100; clr = 4'b0100; tick(); fire = '0; clr = '0;
        chk("R4 fire wins", 64'(status[2]), 64'h1);
        pulse_clr(4'b0100);
        chk("R4 cleared", 64'(status[2]), 64'h0);
        // R6 disabled fire clears a set status
        pulse_fire(4'b0100);
        ch_en[2] = 1'b0;
        pulse_fire(4'b0100);
        chk("R6 status", 64'(status[2]), 64'h0);
        chk("R6 lines", 64'(irq), 64'(IDLE));
        ch_en[2] = 1'b1;

        // R7 legacy override of channels 0 and 1
        legacy = 1'b1;
        ch_level[1:0] = 2'b11;
        set_route(0, 5'd3); set_route(1, 5'd3); set_route(2, 5'd3);
        tick();
        chk("R11 pit_en low", 64'(pit_en), 64'h0);
        pulse_fire(4'b0001);
        chk("R7 ch0 legacy", 64'(irq), 64'(on(0)));
        pulse_clr(4'b0001);
        pulse_fire(4'b0010);
        chk("R7 ch1 legacy", 64'(irq), 64'(on(8)));
        pulse_clr(4'b0010);
        pulse_fire(4'b0100);
        chk("R7 ch2 legacy", 64'(irq), 64'(on(3)));
        pulse_clr(4'b0100);
        legacy = 1'b0;
        tick();

        // R10 pass-through, R11 entry, R12 exit
        pit = 1'b1; tick();
        chk("R10 pit", 64'(irq), 64'(on(0)));
        rtc = 1'b1; tick();
        chk("R10 rtc", 64'(irq), 64'(on(0) ^ (NL'(1) << 8)));
        legacy = 1'b1; tick();
        chk("R11 lines", 64'(irq), 64'(IDLE));
        chk("R11 pit_en", 64'(pit_en), 64'h0);
        legacy = 1'b0; tick();
        chk("R12 lines", 64'(irq), 64'(on(8)));
        chk("R12 pit_en", 64'(pit_en), 64'h1);
        tick();
        chk("R12 line0 back", 64'(irq), 64'(on(0) ^ (NL'(1) << 8)));
        pit = 1'b0; rtc = 1'b0; tick();

        // R9 message enable rise clears status
        ch_level[3] = 1'b1; set_route(3, 5'd6);
        pulse_fire(4'b1000);
        chk("R9 pre", 64'(status[3]), 64'h1);
        ch_msg[3] = 1'b1; tick();
        chk("R9 cleared", 64'(status[3]), 64'h0);
        chk("R9 lines", 64'(irq), 64'(IDLE));

        // R8 message write
        mroute[3*64 +: 64] = {32'hA5A5_0010, 32'h0000_00C3};
        mroute[2*64 +: 64] = {32'h1234_0020, 32'h0000_0077};
        pulse_fire(4'b1000);
        chk("R8 req", 64'(msg_req), 64'h1);
        chk("R8 addr", 64'(msg_addr), 64'hA5A5_0010);
        chk("R8 data", 64'(msg_data), 64'h0000_00C3);
        chk("R8 no line", 64'(irq), 64'(IDLE));
        tick();
        chk("R8 one cycle", 64'(msg_req), 64'h0);
        chk("R8 hold", 64'(msg_addr), 64'hA5A5_0010);
        pulse_fire(4'b1000);
        chk("R8 busy drop", 64'(msg_req), 64'h0);
        ack = 1'b1; tick(); ack = 1'b0;
        ch_msg[2] = 1'b1; tick();
        pulse_fire(4'b1100);
        chk("R8 priority req", 64'(msg_req), 64'h1);
        chk("R8 priority data", 64'(msg_data), 64'h0000_0077);
        chk("R8 priority addr", 64'(msg_addr), 64'h1234_0020);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule